// File: doc/BRIEF.md
# MDIO Station Management Controller

This block lets software reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface. Software fills a 16-bit data register (for writes) and then writes a command register. That register carries the PHY address, the PHY register number, a write/read select, a clock-range code and a busy bit. Setting busy starts one IEEE 802.3 clause-22 frame. The controller generates MDC from the system clock and serialises the frame onto MDIO. On a read it releases the line from the turnaround onwards and captures the returned word. It then clears busy on its own.

MDC is derived from the system clock by a divisor that a 3-bit range code selects. The code-to-divisor mapping is deliberately not monotonic, so that an MDC at or below 2.5 MHz can be reached for system clocks of 25 MHz and above. Every frame is 64 MDC periods long. Software polls the busy bit, and on a read it then takes the PHY value from the data register. The pad is modelled as a simple out/oe/in triple.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The command register holds the PHY address in bits 15:11, the register number in bits 10:6, a spare stored bit in bit 5, the range code in bits 4:2, write-select (1 = write, 0 = read) in bit 1 and busy in bit 0, and `cmd_rdata_o` reads these fields back.
- R2: A write transaction shifts out, one bit per MDC rising edge and MSB first, 32 ones, start 01, opcode 01, the PHY address, the register number, turnaround 10 and the 16 data-register bits, with `mdio_oe_o` high for all 64 bits.
- R3: A read transaction drives 32 ones, start 01, opcode 10, the PHY address and the register number with `mdio_oe_o` high, and holds `mdio_oe_o` low for the remaining 18 bit times (turnaround and data).
- R4: On a read, `mdio_i` is sampled on the MDC rising edges of the last 16 bit times, MSB first, and the word appears on `data_rdata_o` in the same cycle that busy clears.
- R5: Writing the command register with bit 0 set while idle raises `busy_o` at that clock edge. Busy stays high for exactly 64 × divisor clock cycles (64 MDC rising edges) and then clears by itself.
- R6: The range code selects the MDC divisor as 2→16, 3→26, 0→42, 1→62, 4→102, 5→124. MDC is low for the first half of each period and high for the second half.
- R7: The reserved range codes 6 and 7 use the divisor 124.
- R8: `mdio_o` changes only on a falling edge of MDC.
- R9: While no transaction runs, MDC is low, `mdio_oe_o` is low and `mdio_o` is high.
- R10: Writes to the command or data register while busy is high have no effect on the frame, the register contents or the transaction length.
- R11: A write transaction leaves the data register at the value that was sent.
- R12: Asserting `rst_ni` (low, asynchronous) clears both registers and busy, drives MDC low and `mdio_oe_o` low, and aborts a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 16 | Command register write value |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 16 | Data register write value |
| cmd_rdata_o | output | 16 | Command register contents, busy in bit 0 |
| data_rdata_o | output | 16 | Data register contents |
| busy_o | output | 1 | Transaction in progress |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check several rules on every cycle. The half-period counter stays within its limit, MDC toggles only when that counter expires, and MDIO moves only on an MDC fall. Busy is held until the frame ends, the registers stay frozen while busy is high, and the pins are idle whenever busy is low. Only the bench scenarios can show the rest. These are the bit-exact content of read and write frames, the release window on reads, the captured read word, and the exact busy length for every range code including the reserved ones. They also cover discarded writes during a transaction and an abort by reset. The bench plays the PHY for these checks, recording MDIO on each MDC rise and returning data on each fall.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DW         = 16;
  localparam int CODE_W     = 3;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 4 + PHY_AW + REG_AW + 2 + DW;
  localparam int TA_POS     = PRE_BITS + 4 + PHY_AW + REG_AW;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int RATIO_W    = 8;
  localparam int HALF_W     = RATIO_W - 1;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regn;
    logic              spare;
    logic [CODE_W-1:0] code;
    logic              wr;
  } cmd_t;

  // non-monotonic code map; reserved codes take the slowest setting
  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    code_to_ratio = RATIO_W'(42);
      3'd1:    code_to_ratio = RATIO_W'(62);
      3'd2:    code_to_ratio = RATIO_W'(16);
      3'd3:    code_to_ratio = RATIO_W'(26);
      3'd4:    code_to_ratio = RATIO_W'(102);
      default: code_to_ratio = RATIO_W'(124);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic               run_q, mdc_q, tick;
  logic [HALF_W-1:0]  hcnt_q, lim_q, lim_d;
  logic [RATIO_W-1:0] ratio;

  assign ratio = code_to_ratio(code_i);
  assign lim_d = ratio[RATIO_W-1:1] - HALF_W'(1);
  assign tick  = run_q & (hcnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      hcnt_q <= '0;
      lim_q  <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      mdc_q  <= 1'b0;
      hcnt_q <= '0;
      lim_q  <= lim_d;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (run_q) begin
      if (tick) begin
        hcnt_q <= '0;
        mdc_q  <= ~mdc_q;
      end else begin
        hcnt_q <= hcnt_q + HALF_W'(1);
      end
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;

  AST_HALF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> hcnt_q <= lim_q); // R6
  AST_MDC_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$past(tick) && !$past(start_i)) |-> $stable(mdc_q)); // R6
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  cmd_t          cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic                  active_q, rd_q, last_bit, in_rx, in_release;
  logic [CNT_W-1:0]      bitcnt_q;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [DW-1:0]         rsh_q;

  assign frame_d = {{PRE_BITS{1'b1}}, 2'b01,
                    (cmd_i.wr ? 2'b01 : 2'b10),
                    cmd_i.phy, cmd_i.regn, 2'b10,
                    (cmd_i.wr ? wdata_i : {DW{1'b0}})};

  assign last_bit   = (bitcnt_q == CNT_W'(FRAME_BITS - 1));
  assign in_rx      = rd_q & (bitcnt_q >= CNT_W'(DATA_POS));
  assign in_release = rd_q & (bitcnt_q >= CNT_W'(TA_POS));
  assign done_o     = active_q & fall_i & last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      bitcnt_q <= '0;
      frame_q  <= '1;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= ~cmd_i.wr;
      bitcnt_q <= '0;
      frame_q  <= frame_d;
    end else if (done_o) begin
      active_q <= 1'b0;
      bitcnt_q <= '0;
      frame_q  <= '1;
    end else if (active_q && fall_i) begin
      bitcnt_q <= bitcnt_q + CNT_W'(1);
      frame_q  <= {frame_q[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsh_q <= '0;
    else if (active_q && rise_i && in_rx) rsh_q <= {rsh_q[DW-2:0], mdio_i};
  end

  assign rdata_o   = rsh_q;
  assign mdio_o    = active_q ? frame_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = active_q & ~in_release;

  AST_MDIO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(fall_i)) |-> $stable(mdio_o)); // R8
  AST_NO_DRIVE_IN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && in_rx) |-> !mdio_oe_o); // R3
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [15:0]   cmd_wdata_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_wdata_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          start_o,
  output cmd_t          new_cmd_o,
  output logic          busy_o,
  output logic [15:0]   cmd_rdata_o,
  output logic [DW-1:0] data_o
);
  cmd_t          cmd_q;
  logic          busy_q;
  logic [DW-1:0] data_q;

  assign new_cmd_o = cmd_t'(cmd_wdata_i[15:1]);
  assign start_o   = cmd_we_i & ~busy_q & cmd_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else if (cmd_we_i && !busy_q) begin
      cmd_q  <= new_cmd_o;
      busy_q <= cmd_wdata_i[0];
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (data_we_i && !busy_q) data_q <= data_wdata_i;
    else if (done_i && !cmd_q.wr) data_q <= rx_data_i;
  end

  assign busy_o      = busy_q;
  assign cmd_rdata_o = {cmd_q, busy_q};
  assign data_o      = data_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> busy_q); // R5
  AST_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(cmd_q)); // R10
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_q) && !$past(done_i)) |-> $stable(data_q)); // R10
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [15:0] cmd_wdata_i,
  input  logic        data_we_i,
  input  logic [15:0] data_wdata_i,
  output logic [15:0] cmd_rdata_o,
  output logic [15:0] data_rdata_o,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic          start, done, rise, fall;
  cmd_t          new_cmd;
  logic [DW-1:0] data_q, rx_data;

  mdio_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .data_we_i    (data_we_i),
    .data_wdata_i (data_wdata_i),
    .done_i       (done),
    .rx_data_i    (rx_data),
    .start_o      (start),
    .new_cmd_o    (new_cmd),
    .busy_o       (busy_o),
    .cmd_rdata_o  (cmd_rdata_o),
    .data_o       (data_q)
  );

  mdio_clkdiv u_clkdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .stop_i  (done),
    .code_i  (new_cmd.code),
    .mdc_o   (mdc_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (new_cmd),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .done_o    (done),
    .rdata_o   (rx_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .mdio_i    (mdio_i)
  );

  assign data_rdata_o = data_q;

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o && mdio_o)); // R9
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> busy_o); // R5
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0, data_we = 1'b0;
  logic [15:0] cmd_wd = '0, data_wd = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic        busy, mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int fails  = 0;

  // phy model state
  int          rc = 0;
  int          hi_cnt = 0;
  int          viol = 0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] phy_val = '0;
  logic        pm = 1'b1, pc = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .data_we_i(data_we), .data_wdata_i(data_wd),
    .cmd_rdata_o(cmd_rdata), .data_rdata_o(data_rdata),
    .busy_o(busy), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_out};
    oecap = {oecap[62:0], mdio_oe};
    rc    = rc + 1;
  end

  always @(negedge mdc) begin
    if (rc >= 48 && rc <= 63) mdio_in = phy_val[63-rc];
    else mdio_in = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc) hi_cnt = hi_cnt + 1;
    if (rst_ni && mdio_out != pm && !(pc && !mdc)) viol = viol + 1;
    pm = mdio_out;
    pc = mdc;
  end

  // {wr, code[2:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 3'd0, 5'h01, 5'h00, 16'h1200},
    {1'b0, 3'd1, 5'h1F, 5'h01, 16'h7809},
    {1'b1, 3'd2, 5'h00, 5'h1F, 16'hA5A5},
    {1'b0, 3'd3, 5'h15, 5'h0A, 16'h5A5A},
    {1'b1, 3'd4, 5'h0A, 5'h15, 16'hFFFF},
    {1'b0, 3'd5, 5'h03, 5'h02, 16'h0001},
    {1'b1, 3'd6, 5'h1E, 5'h11, 16'h8000},
    {1'b0, 3'd7, 5'h11, 5'h1E, 16'hC3C3}
  };

  function automatic int exp_ratio(input logic [2:0] c);
    case (c)
      3'd2: return 16;
      3'd3: return 26;
      3'd0: return 42;
      3'd1: return 62;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [2:0] code, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] dat, input bit poke);
    int cyc;
    int r;
    string rt;
    r  = exp_ratio(code);
    rt = (code > 3'd5) ? "R7 reserved code divisor" : "R6 divisor";
    phy_val = dat;
    if (wr) begin
      @(negedge clk); data_we = 1'b1; data_wd = dat;
      @(negedge clk); data_we = 1'b0;
    end
    rc = 0; cap = '0; oecap = '0; hi_cnt = 0;
    @(negedge clk); cmd_we = 1'b1; cmd_wd = {phy, rg, 1'b0, code, wr, 1'b1};
    @(negedge clk); cmd_we = 1'b0;
    chk("R5 busy raised after command write", 64'(busy), 64'd1);
    cyc = 0;
    while (busy) begin
      if (poke && cyc == 10) begin
        data_we = 1'b1; data_wd = 16'hDEAD; cmd_we = 1'b1; cmd_wd = 16'hFFFF;
      end
      if (poke && cyc == 11) begin
        data_we = 1'b0; cmd_we = 1'b0;
      end
      @(negedge clk); cyc++;
    end
    chk({rt, " busy length"}, 64'(cyc), 64'(64 * r));
    chk({rt, " MDC high time"}, 64'(hi_cnt), 64'(32 * r));
    chk("R5 MDC rising edges per frame", 64'(rc), 64'd64);
    chk("R9 idle pins mdc/oe/out", {61'd0, mdc, mdio_oe, mdio_out}, 64'b001);
    chk(poke ? "R10 command held while busy" : "R1 command readback",
        64'(cmd_rdata), 64'({phy, rg, 1'b0, code, wr, 1'b0}));
    if (wr) begin
      chk(poke ? "R10 write frame unaffected" : "R2 write frame",
          cap, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, dat});
      chk("R2 oe held during write", oecap, '1);
      chk(poke ? "R10 data held while busy" : "R11 data unchanged after write",
          64'(data_rdata), 64'(dat));
    end else begin
      chk("R3 read header", 64'(cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg}));
      chk("R3 read release window", oecap, {{46{1'b1}}, 18'd0});
      chk("R4 read data returned", 64'(data_rdata), 64'(dat));
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 64'(busy), 64'd0);
    chk("R12 reset registers", {32'd0, cmd_rdata, data_rdata}, 64'd0);
    chk("R12 reset pins mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {61'd0, mdc, mdio_oe, mdio_out}, 64'b001);

    for (int i = 0; i < 8; i++)
      run_txn(VEC[i][29], VEC[i][28:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);

    // writes during busy must be dropped
    run_txn(1'b1, 3'd2, 5'h05, 5'h03, 16'h1234, 1'b1);
    run_txn(1'b0, 3'd3, 5'h09, 5'h04, 16'hBEEF, 1'b1);

    // abort by reset mid-frame
    @(negedge clk); cmd_we = 1'b1; cmd_wd = {5'h02, 5'h07, 1'b0, 3'd2, 1'b0, 1'b1};
    @(negedge clk); cmd_we = 1'b0;
    repeat (50) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R12 abort clears busy", 64'(busy), 64'd0);
    chk("R12 abort pins mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    chk("R12 abort clears registers", {32'd0, cmd_rdata, data_rdata}, 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    run_txn(1'b1, 3'd3, 5'h0C, 5'h0D, 16'h0F0F, 1'b0);

    chk("R8 MDIO moved only on MDC fall", 64'(viol), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule